// File: doc/BRIEF.md
# Dual-Processor Mailbox Handshake Controller

This block coordinates data exchange between a local processor and an external master processor that share two data locations: a lead slot and a last slot. It does not store the data. It watches single-cycle read and write strobes from each side and keeps eight control and completion bits in one status byte. Both sides can read the byte, but only the local side can change its three enable bits.

Ownership of the lead slot is held by a three-state machine. The states are `OWN_IDLE`, `OWN_MASTER` and `OWN_LOCAL`. The side that writes the lead slot first takes ownership. If both sides write it in the same cycle, the master wins. The transitions are:
- `OWN_IDLE -> OWN_MASTER` when the master writes the lead slot.
- `OWN_IDLE -> OWN_LOCAL` when only the local side writes the lead slot.
- `OWN_MASTER -> OWN_IDLE` when the local side reads the lead slot and the master is not rewriting it.
- `OWN_LOCAL -> OWN_IDLE` when the master reads the lead slot and the local side is not rewriting it.

Each completion flag is set by one side's access and cleared by the other side's access. The block drives two level interrupt requests to the local processor. It also drives a ready pin toward the master; that pin can be tristated.

Top module: `mbox_handshake`

## Requirements
- R1: After reset, the status byte is 0x00, both interrupt requests are low and the ready pin is not enabled.
- R2: Select codes are 0 for the lead slot, 1 for the last slot and 2 for the status byte. A local write to the status byte loads only bit 6 (write-done interrupt enable), bit 4 (ready enable) and bit 2 (read-done interrupt enable) from the write data. A master write to the status byte has no effect.
- R3: Bit 7 (master-wrote-last) sets after a master write of the last slot. It clears after a local read of the last slot, but only while bit 1 (master owns lead) is 1.
- R4: Bit 5 (local-wrote-last) sets after a local write of the last slot and clears after a master read of the last slot.
- R5: Bit 3 (master-read-lead) sets after a master read of the lead slot. It clears after a local read or write of the lead slot, or after a master write of the lead slot.
- R6: Bit 1 (master owns lead) sets on a master lead write while bit 0 is 0, and clears on a local lead read. Bit 0 (local owns lead) sets on a local lead write while bit 1 is 0, and clears on a master lead read.
- R7: When both sides write the lead slot in the same cycle with bits 1 and 0 both at 0, only bit 1 sets. Bits 1 and 0 are never both 1.
- R8: When a set and a clear of the same flag occur in the same cycle, the flag ends up at 1.
- R9: `irq_mw` is high exactly when bits 7 and 6 are both 1. `irq_mr` is high exactly when bits 3 and 2 are both 1.
- R10: `rdy_oe` equals bit 4. When it is 1, `rdy_o` drives the value of bit 5. When it is 0, `rdy_o` is high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_rd | input | 1 | Local read strobe |
| loc_wr | input | 1 | Local write strobe |
| loc_sel | input | 2 | Local register select |
| loc_wdata | input | 8 | Local write data for the status byte |
| mst_rd | input | 1 | Master read strobe |
| mst_wr | input | 1 | Master write strobe |
| mst_sel | input | 2 | Master register select |
| stat_o | output | 8 | Status byte, readable by both sides |
| irq_mw | output | 1 | Master-write-done interrupt request |
| irq_mr | output | 1 | Master-read-done interrupt request |
| rdy_oe | output | 1 | Ready pin output enable |
| rdy_o | output | 1 | Ready pin, tristated when disabled |

## Verification
The bench targets the following corner cases:
- **Simultaneous lead writes.** A design with the wrong priority would give ownership to the local side, or set both mode bits.
- **Local read of the last slot while the master does not own the lead.** A design that ignores the ownership guard would clear bit 7 too early.
- **Colliding set and clear of the same flag.** A design that lets clear win would drop a completion event.
- **Second writer.** A master lead write during local ownership, and the reverse, must leave the mode bits unchanged. A design that let the later writer take over would hand the slot to both sides.
- **Enable masking.** The bench checks that the interrupts and the ready pin follow the enables. A design that forgot the enables would request service with interrupts turned off.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int SEL_W  = 2;
    localparam int STAT_W = 8;

    localparam logic [SEL_W-1:0] SEL_LEAD = 2'd0;
    localparam logic [SEL_W-1:0] SEL_LAST = 2'd1;
    localparam logic [SEL_W-1:0] SEL_STAT = 2'd2;

    // Status bit positions; the local side decodes these.
    localparam int B_MWE  = 7;
    localparam int B_EMW  = 6;
    localparam int B_LWE  = 5;
    localparam int B_RDYE = 4;
    localparam int B_MRE  = 3;
    localparam int B_EMR  = 2;
    localparam int B_MOWN = 1;
    localparam int B_LOWN = 0;

    localparam int NFLAG = 3;

    typedef enum logic [1:0] {
        OWN_IDLE   = 2'd0,
        OWN_MASTER = 2'd1,
        OWN_LOCAL  = 2'd2
    } own_state_t;
endpackage

// File: rtl/mbox_own_fsm.sv
module mbox_own_fsm
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mst_wr_lead,
    input  logic mst_rd_lead,
    input  logic loc_wr_lead,
    input  logic loc_rd_lead,
    output logic mst_own,
    output logic loc_own
);
    own_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OWN_IDLE: begin
                if (mst_wr_lead)
                    state_d = OWN_MASTER;
                else if (loc_wr_lead)
                    state_d = OWN_LOCAL;
            end
            OWN_MASTER: begin
                if (loc_rd_lead && !mst_wr_lead)
                    state_d = OWN_IDLE;
            end
            OWN_LOCAL: begin
                if (mst_rd_lead && !loc_wr_lead)
                    state_d = OWN_IDLE;
            end
            default: state_d = OWN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= OWN_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        mst_own = 1'b0;
        loc_own = 1'b0;
        unique case (state_q)
            OWN_IDLE:   ;
            OWN_MASTER: mst_own = 1'b1;
            OWN_LOCAL:  loc_own = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/mbox_flag_cell.sv
module mbox_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end
endmodule

// File: rtl/mbox_handshake.sv
module mbox_handshake
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_rd,
    input  logic              loc_wr,
    input  logic [SEL_W-1:0]  loc_sel,
    input  logic [STAT_W-1:0] loc_wdata,
    input  logic              mst_rd,
    input  logic              mst_wr,
    input  logic [SEL_W-1:0]  mst_sel,
    output logic [STAT_W-1:0] stat_o,
    output logic              irq_mw,
    output logic              irq_mr,
    output logic              rdy_oe,
    output wire               rdy_o
);
    localparam int F_MWE = 0;
    localparam int F_LWE = 1;
    localparam int F_MRE = 2;

    logic mst_wr_lead, mst_rd_lead, loc_wr_lead, loc_rd_lead;
    logic mst_wr_last, mst_rd_last, loc_wr_last, loc_rd_last;
    logic loc_wr_stat;
    logic mst_own, loc_own;
    logic en_mw_q, en_rdy_q, en_mr_q;
    logic [NFLAG-1:0] f_set, f_clr, f_q;

    always_comb begin
        mst_wr_lead = mst_wr && (mst_sel == SEL_LEAD);
        mst_rd_lead = mst_rd && (mst_sel == SEL_LEAD);
        loc_wr_lead = loc_wr && (loc_sel == SEL_LEAD);
        loc_rd_lead = loc_rd && (loc_sel == SEL_LEAD);
        mst_wr_last = mst_wr && (mst_sel == SEL_LAST);
        mst_rd_last = mst_rd && (mst_sel == SEL_LAST);
        loc_wr_last = loc_wr && (loc_sel == SEL_LAST);
        loc_rd_last = loc_rd && (loc_sel == SEL_LAST);
        loc_wr_stat = loc_wr && (loc_sel == SEL_STAT);
    end

    mbox_own_fsm u_own (
        .clk         (clk),
        .rst_n       (rst_n),
        .mst_wr_lead (mst_wr_lead),
        .mst_rd_lead (mst_rd_lead),
        .loc_wr_lead (loc_wr_lead),
        .loc_rd_lead (loc_rd_lead),
        .mst_own     (mst_own),
        .loc_own     (loc_own)
    );

    always_comb begin
        f_set[F_MWE] = mst_wr_last;
        f_clr[F_MWE] = loc_rd_last && mst_own;
        f_set[F_LWE] = loc_wr_last;
        f_clr[F_LWE] = mst_rd_last;
        f_set[F_MRE] = mst_rd_lead;
        f_clr[F_MRE] = loc_rd_lead || loc_wr_lead || mst_wr_lead;
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        mbox_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (f_set[g]),
            .clr_i  (f_clr[g]),
            .flag_o (f_q[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_mw_q  <= 1'b0;
            en_rdy_q <= 1'b0;
            en_mr_q  <= 1'b0;
        end else if (loc_wr_stat) begin
            en_mw_q  <= loc_wdata[B_EMW];
            en_rdy_q <= loc_wdata[B_RDYE];
            en_mr_q  <= loc_wdata[B_EMR];
        end
    end

    always_comb begin
        stat_o         = '0;
        stat_o[B_MWE]  = f_q[F_MWE];
        stat_o[B_EMW]  = en_mw_q;
        stat_o[B_LWE]  = f_q[F_LWE];
        stat_o[B_RDYE] = en_rdy_q;
        stat_o[B_MRE]  = f_q[F_MRE];
        stat_o[B_EMR]  = en_mr_q;
        stat_o[B_MOWN] = mst_own;
        stat_o[B_LOWN] = loc_own;
        irq_mw         = f_q[F_MWE] && en_mw_q;
        irq_mr         = f_q[F_MRE] && en_mr_q;
        rdy_oe         = en_rdy_q;
    end

    assign rdy_o = en_rdy_q ? f_q[F_LWE] : 1'bz;
endmodule

// File: rtl/mbox_handshake_chk.sv
module mbox_handshake_chk
    import mbox_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              loc_rd,
    input logic              loc_wr,
    input logic [SEL_W-1:0]  loc_sel,
    input logic              mst_rd,
    input logic              mst_wr,
    input logic [SEL_W-1:0]  mst_sel,
    input logic [STAT_W-1:0] stat_o,
    input logic              irq_mw,
    input logic              irq_mr,
    input logic              rdy_oe
);
    AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_o[B_MOWN] && stat_o[B_LOWN])); // R7

    AST_MASTER_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_wr && mst_sel == SEL_LEAD && loc_wr && loc_sel == SEL_LEAD &&
         !stat_o[B_MOWN] && !stat_o[B_LOWN])
        |=> (stat_o[B_MOWN] && !stat_o[B_LOWN])); // R7

    AST_ENABLES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_wr && loc_sel == SEL_STAT)
        |=> $stable({stat_o[B_EMW], stat_o[B_RDYE], stat_o[B_EMR]})); // R2

    AST_MWE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_wr && mst_sel == SEL_LAST) |=> stat_o[B_MWE]); // R3

    AST_LWE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_wr && loc_sel == SEL_LAST) |=> stat_o[B_LWE]); // R4

    AST_MRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_rd && mst_sel == SEL_LEAD) |=> stat_o[B_MRE]); // R5

    AST_IRQ_MW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mw |-> (stat_o[B_EMW] && stat_o[B_MWE])); // R9

    AST_IRQ_MR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mr |-> (stat_o[B_EMR] && stat_o[B_MRE])); // R9

    AST_RDY_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_oe |-> stat_o[B_RDYE]); // R10
endmodule

bind mbox_handshake mbox_handshake_chk u_chk (.*);

// File: tb/tb_mbox_handshake.sv
`timescale 1ns/1ps
module tb_mbox_handshake;
    import mbox_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic loc_rd = 0, loc_wr = 0, mst_rd = 0, mst_wr = 0;
    logic [1:0] loc_sel = 0, mst_sel = 0;
    logic [7:0] loc_wdata = 0;
    logic [7:0] stat_o;
    logic irq_mw, irq_mr, rdy_oe;
    wire  rdy_o;

    always #2 clk = ~clk; // 250 MHz

    mbox_handshake dut (
        .clk(clk), .rst_n(rst_n),
        .loc_rd(loc_rd), .loc_wr(loc_wr), .loc_sel(loc_sel), .loc_wdata(loc_wdata),
        .mst_rd(mst_rd), .mst_wr(mst_wr), .mst_sel(mst_sel),
        .stat_o(stat_o), .irq_mw(irq_mw), .irq_mr(irq_mr),
        .rdy_oe(rdy_oe), .rdy_o(rdy_o)
    );

    typedef struct {
        logic [7:0] stat;
        logic       imw;
        logic       imr;
        logic       oe;
        string      tag;
    } exp_t;

    exp_t q[$];
    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // reference model state, derived from the requirements
    bit m_mwe, m_emw, m_lwe, m_rdy, m_mre, m_emr, m_mown, m_lown;

    function automatic logic [7:0] m_stat();
        return {m_mwe, m_emw, m_lwe, m_rdy, m_mre, m_emr, m_mown, m_lown};
    endfunction

    task automatic vec(input bit lr, input bit lw, input logic [1:0] ls,
                       input logic [7:0] wd, input bit mr, input bit mw,
                       input logic [1:0] ms, input string tag);
        bit lwl, lrl, mwl, mrl, lwt, lrt, mwt, mrt, lws;
        bit n_mown, n_lown, n_mwe, n_lwe, n_mre;
        exp_t e;
        @(negedge clk);
        loc_rd = lr; loc_wr = lw; loc_sel = ls; loc_wdata = wd;
        mst_rd = mr; mst_wr = mw; mst_sel = ms;
        lwl = lw && ls == 0; lrl = lr && ls == 0;
        mwl = mw && ms == 0; mrl = mr && ms == 0;
        lwt = lw && ls == 1; lrt = lr && ls == 1;
        mwt = mw && ms == 1; mrt = mr && ms == 1;
        lws = lw && ls == 2;
        n_mown = (mwl && !m_lown) || (m_mown && !lrl);
        n_lown = (lwl && !m_mown && !(mwl && !m_lown)) || (m_lown && !mrl);
        n_mwe  = mwt || (m_mwe && !(lrt && m_mown));
        n_lwe  = lwt || (m_lwe && !mrt);
        n_mre  = mrl || (m_mre && !(lrl || lwl || mwl));
        if (lws) begin m_emw = wd[6]; m_rdy = wd[4]; m_emr = wd[2]; end
        m_mown = n_mown; m_lown = n_lown;
        m_mwe = n_mwe; m_lwe = n_lwe; m_mre = n_mre;
        e.stat = m_stat();
        e.imw  = m_mwe && m_emw;
        e.imr  = m_mre && m_emr;
        e.oe   = m_rdy;
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        vec(0, 0, 0, 8'h00, 0, 0, 0, tag);
    endtask

    // monitor: compare after each edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_vec++;
                if (stat_o !== e.stat || irq_mw !== e.imw || irq_mr !== e.imr ||
                    rdy_oe !== e.oe || (e.oe && rdy_o !== e.stat[5])) begin
                    n_bad++;
                    $display("FAIL %s: stat=%h irq=%b%b oe=%b rdy=%b expected stat=%h irq=%b%b oe=%b rdy=%b",
                             e.tag, stat_o, irq_mw, irq_mr, rdy_oe, rdy_o,
                             e.stat, e.imw, e.imr, e.oe, e.stat[5]);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset state");
        vec(0, 1, 2, 8'hFF, 0, 0, 0, "R2 local status write loads enables only");
        vec(0, 0, 0, 8'h00, 0, 1, 2, "R2 master status write ignored");
        vec(0, 0, 0, 8'h00, 0, 1, 1, "R3 R9 master writes last slot");
        vec(1, 0, 1, 8'h00, 0, 0, 0, "R3 local last read without master ownership keeps flag");
        vec(0, 0, 0, 8'h00, 0, 1, 0, "R6 master takes lead");
        vec(0, 1, 0, 8'h00, 0, 0, 0, "R6 local lead write while master owns");
        vec(1, 0, 1, 8'h00, 0, 0, 0, "R3 local last read clears under ownership");
        vec(1, 0, 0, 8'h00, 0, 0, 0, "R6 local lead read releases master");
        vec(0, 1, 0, 8'h00, 0, 0, 0, "R6 local takes lead");
        vec(0, 0, 0, 8'h00, 0, 1, 0, "R6 master lead write while local owns");
        vec(0, 0, 0, 8'h00, 1, 0, 0, "R5 R6 R9 master lead read");
        vec(0, 1, 1, 8'h00, 0, 0, 0, "R4 R10 local writes last slot");
        vec(0, 0, 0, 8'h00, 1, 0, 1, "R4 master reads last slot");
        vec(0, 1, 0, 8'h00, 0, 1, 0, "R7 simultaneous lead writes");
        vec(0, 0, 0, 8'h00, 1, 0, 0, "R5 master lead read with master owning");
        vec(1, 0, 0, 8'h00, 1, 0, 0, "R8 read-end set beats local clear");
        vec(0, 0, 0, 8'h00, 0, 1, 0, "R6 master retakes lead");
        vec(1, 0, 1, 8'h00, 0, 1, 1, "R8 write-end set beats clear");
        vec(0, 1, 2, 8'h00, 0, 0, 0, "R9 R10 enables off mask requests");
        vec(0, 1, 1, 8'h00, 0, 0, 0, "R10 ready pin stays disabled");
        vec(0, 1, 2, 8'h10, 0, 0, 0, "R10 ready enabled alone");
        idle("R1 R10 hold");
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule